// File: doc/BRIEF.md
# Dual-Port Host Bridge Register File

This block is a bank of 64-bit control and status registers for a host bridge. Two access paths reach the same storage. The scan port addresses a register by byte address, and its register index is that address shifted right by three. The memory-mapped port addresses a register by byte offset, and its index is the offset shifted right by three plus ten. Only whole, 8-byte aligned 64-bit words are legal. Data passes through unchanged, most significant byte first, as one 64-bit word.

The bank holds:
- a fault register, with AND and OR alias indices;
- a fault mask, with AND and OR alias indices;
- two fault action registers;
- a bridge base register with an enable bit in bit 0;
- a service-processor base register;
- a control/status register, with set and clear alias indices;
- a status/error mask;
- a DMA upper address;
- a read-only interrupt status register, which samples external level inputs.

Illegal or unmapped accesses raise a one-cycle error pulse. A separate strobe reports each change of the control register's memory-mapped-enable bit (bit 62).

Top module: `hostbridge_regfile`

## Requirements
- R1: After reset every register reads zero, except the base register (index 0x0A). It reads (BAR_DFLT & BAR_MASK) with bit 0 set. No read-valid, error or strobe output is high.
- R2: A memory-mapped access at byte offset `o` reaches register index (o >> 3) + 0x0A. A scan access at byte address `a` reaches index a >> 3. An index above 0x3F is unmapped.
- R3: Index 0x00 loads the fault register, 0x01 ANDs the write data into it, and 0x02 ORs the write data into it. Indices 0x03, 0x04 and 0x05 do the same for the fault mask. Indices 0x06 and 0x07 are plain action registers.
- R4: A write to index 0x12 sets the control register (0x0E) bits that are one in the data. A write to index 0x13 clears the control register bits that are one in the data. Index 0x0E loads the control register directly. Indices 0x0F and 0x14 are plain registers.
- R5: Only the scan port can write the base register. A memory-mapped write to it leaves the register unchanged and pulses `err_pulse`.
- R6: A write to the base register stores data & (BAR_MASK | 1). A write to index 0x0B stores data & FSP_MASK.
- R7: The interrupt status register (0x15) holds `int_level` at bits [32 +: INT_N], one cycle after the input. A write to it has no effect and pulses `err_pulse`.
- R8: These indices are readable: 0x00, 0x03, 0x06, 0x07, 0x0A, 0x0B, 0x0E, 0x0F, 0x14 and 0x15. A read of any other index returns all ones and pulses `err_pulse`. A write to an index that has no write action pulses `err_pulse` and changes nothing.
- R9: An access whose address bits [2:0] are not zero is illegal. It pulses `err_pulse`, a write is dropped, and a read returns all ones.
- R10: Read data and its valid appear in the cycle after the accepted request. `scn_ready` is always high. `mm_ready` is low whenever `scn_valid` is high, so the scan port wins.
- R11: `mmio_en_chg` pulses for one cycle after any accepted write that changes control bit 62, and at no other time.
- R12: `err_pulse` is high for exactly the cycle after an offending access, and never after a legal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scn_valid | input | 1 | Scan request valid |
| scn_ready | output | 1 | Scan request accepted |
| scn_we | input | 1 | Scan write (1) or read (0) |
| scn_addr | input | SC_AW | Scan byte address |
| scn_wdata | input | 64 | Scan write data |
| scn_rvalid | output | 1 | Scan read data valid |
| scn_rdata | output | 64 | Scan read data |
| mm_valid | input | 1 | Memory-mapped request valid |
| mm_ready | output | 1 | Memory-mapped request accepted |
| mm_we | input | 1 | Memory-mapped write (1) or read (0) |
| mm_addr | input | MM_AW | Memory-mapped byte offset |
| mm_wdata | input | 64 | Memory-mapped write data |
| mm_rvalid | output | 1 | Memory-mapped read data valid |
| mm_rdata | output | 64 | Memory-mapped read data |
| int_level | input | INT_N | Interrupt levels sampled into the status register |
| err_pulse | output | 1 | Illegal or unmapped access seen |
| mmio_en_chg | output | 1 | Control bit 62 changed |

## Verification
The bench uses the defaults: a 9-bit scan address, an 8-bit memory-mapped offset and five status levels. It also sets a base default with bits outside BAR_MASK, so the reset masking is visible. With these sizes it sweeps every one of the 64 scan indices, reading, writing and reading again, and every aligned memory-mapped offset. That covers each alias, each masked store and each unmapped hole in the index space. A reference model in the bench predicts every read value, error pulse and strobe. Directed steps add misaligned addresses, a memory-mapped write to the base register, enable-bit toggles and a same-cycle collision of both ports.

// File: rtl/hbrf_pkg.sv
package hbrf_pkg;
  localparam int DW    = 64;
  localparam int IDX_W = 6;
  localparam int NREG  = 1 << IDX_W;

  localparam logic [IDX_W-1:0] IX_FLT      = 6'h00;
  localparam logic [IDX_W-1:0] IX_FLT_AND  = 6'h01;
  localparam logic [IDX_W-1:0] IX_FLT_OR   = 6'h02;
  localparam logic [IDX_W-1:0] IX_FMSK     = 6'h03;
  localparam logic [IDX_W-1:0] IX_FMSK_AND = 6'h04;
  localparam logic [IDX_W-1:0] IX_FMSK_OR  = 6'h05;
  localparam logic [IDX_W-1:0] IX_ACT0     = 6'h06;
  localparam logic [IDX_W-1:0] IX_ACT1     = 6'h07;
  localparam logic [IDX_W-1:0] IX_BASE     = 6'h0A;
  localparam logic [IDX_W-1:0] IX_SPBASE   = 6'h0B;
  localparam logic [IDX_W-1:0] IX_CTL      = 6'h0E;
  localparam logic [IDX_W-1:0] IX_EMASK    = 6'h0F;
  localparam logic [IDX_W-1:0] IX_CTL_SET  = 6'h12;
  localparam logic [IDX_W-1:0] IX_CTL_CLR  = 6'h13;
  localparam logic [IDX_W-1:0] IX_DMAHI    = 6'h14;
  localparam logic [IDX_W-1:0] IX_ISTAT    = 6'h15;

  localparam int MM_BASE_IDX  = 10;
  localparam int CTL_MMIO_BIT = 62;

  typedef struct packed {
    logic             vld;
    logic             we;
    logic             mm;
    logic             ok;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    wd;
  } acc_t;
endpackage

// File: rtl/hb_port_decode.sv
module hb_port_decode
  import hbrf_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int BASE_IDX = 0,
  parameter bit IS_MM    = 1'b0
) (
  input  logic              valid,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output acc_t              acc
);
  localparam int SUM_W = 32;

  logic [SUM_W-1:0] wide;

  always_comb begin
    wide    = SUM_W'(addr >> 3) + SUM_W'(BASE_IDX);
    acc.vld = valid;
    acc.we  = we;
    acc.mm  = IS_MM;
    acc.ok  = (addr[2:0] == 3'b000) && (wide < SUM_W'(NREG));
    acc.idx = wide[IDX_W-1:0];
    acc.wd  = wdata;
  end
endmodule

// File: rtl/hb_reg_core.sv
module hb_reg_core
  import hbrf_pkg::*;
#(
  parameter int          INT_N     = 5,
  parameter int          INT_LSB   = 32,
  parameter logic [63:0] BAR_DFLT  = 64'h0,
  parameter logic [63:0] BAR_MASK  = 64'h0003_FFFF_FFF0_0000,
  parameter logic [63:0] FSP_MASK  = 64'h0003_FFFF_0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  acc_t             acc,
  input  logic [INT_N-1:0] int_level,
  output logic [DW-1:0]    rd_val,
  output logic             bad,
  output logic             mmio_chg
);
  localparam logic [DW-1:0] BASE_KEEP = BAR_MASK | 64'h1;
  localparam logic [DW-1:0] BASE_RST  = (BAR_DFLT & BAR_MASK) | 64'h1;

  logic [DW-1:0] flt, fmsk, act0, act1, base, spbase, ctl, emask, dmahi, istat;
  logic [DW-1:0] flt_n, fmsk_n, act0_n, act1_n, base_n, spbase_n, ctl_n, emask_n, dmahi_n;
  logic [DW-1:0] istat_n;

  always_comb begin
    istat_n = '0;
    istat_n[INT_LSB +: INT_N] = int_level;
  end

  always_comb begin
    flt_n = flt;   fmsk_n = fmsk;     act0_n = act0;   act1_n = act1;
    base_n = base; spbase_n = spbase; ctl_n = ctl;     emask_n = emask;
    dmahi_n = dmahi;
    bad    = 1'b0;
    rd_val = '1;
    if (acc.vld) begin
      if (!acc.ok) begin
        bad = 1'b1;
      end else if (acc.we) begin
        unique case (acc.idx)
          IX_FLT:      flt_n   = acc.wd;
          IX_FLT_AND:  flt_n   = flt & acc.wd;
          IX_FLT_OR:   flt_n   = flt | acc.wd;
          IX_FMSK:     fmsk_n  = acc.wd;
          IX_FMSK_AND: fmsk_n  = fmsk & acc.wd;
          IX_FMSK_OR:  fmsk_n  = fmsk | acc.wd;
          IX_ACT0:     act0_n  = acc.wd;
          IX_ACT1:     act1_n  = acc.wd;
          IX_BASE: begin
            if (acc.mm) bad = 1'b1;
            else        base_n = acc.wd & BASE_KEEP;
          end
          IX_SPBASE:   spbase_n = acc.wd & FSP_MASK;
          IX_CTL:      ctl_n   = acc.wd;
          IX_CTL_SET:  ctl_n   = ctl | acc.wd;
          IX_CTL_CLR:  ctl_n   = ctl & ~acc.wd;
          IX_EMASK:    emask_n = acc.wd;
          IX_DMAHI:    dmahi_n = acc.wd;
          default:     bad     = 1'b1;
        endcase
      end else begin
        unique case (acc.idx)
          IX_FLT:    rd_val = flt;
          IX_FMSK:   rd_val = fmsk;
          IX_ACT0:   rd_val = act0;
          IX_ACT1:   rd_val = act1;
          IX_BASE:   rd_val = base;
          IX_SPBASE: rd_val = spbase;
          IX_CTL:    rd_val = ctl;
          IX_EMASK:  rd_val = emask;
          IX_DMAHI:  rd_val = dmahi;
          IX_ISTAT:  rd_val = istat;
          default:   bad    = 1'b1;
        endcase
      end
    end
    mmio_chg = ctl_n[CTL_MMIO_BIT] ^ ctl[CTL_MMIO_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flt <= '0; fmsk <= '0; act0 <= '0; act1 <= '0;
      base <= BASE_RST; spbase <= '0; ctl <= '0; emask <= '0;
      dmahi <= '0; istat <= '0;
    end else begin
      flt <= flt_n; fmsk <= fmsk_n; act0 <= act0_n; act1 <= act1_n;
      base <= base_n; spbase <= spbase_n; ctl <= ctl_n; emask <= emask_n;
      dmahi <= dmahi_n; istat <= istat_n;
    end
  end
endmodule

// File: rtl/hb_read_return.sv
module hb_read_return #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit,
  input  logic [W-1:0] data,
  output logic         rvalid,
  output logic [W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= hit;
      if (hit) rdata <= data;
    end
  end
endmodule

// File: rtl/hostbridge_regfile.sv
module hostbridge_regfile
  import hbrf_pkg::*;
#(
  parameter int          SC_AW    = 9,
  parameter int          MM_AW    = 8,
  parameter int          INT_N    = 5,
  parameter int          INT_LSB  = 32,
  parameter logic [63:0] BAR_DFLT = 64'h0,
  parameter logic [63:0] BAR_MASK = 64'h0003_FFFF_FFF0_0000,
  parameter logic [63:0] FSP_MASK = 64'h0003_FFFF_0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scn_valid,
  output logic             scn_ready,
  input  logic             scn_we,
  input  logic [SC_AW-1:0] scn_addr,
  input  logic [63:0]      scn_wdata,
  output logic             scn_rvalid,
  output logic [63:0]      scn_rdata,
  input  logic             mm_valid,
  output logic             mm_ready,
  input  logic             mm_we,
  input  logic [MM_AW-1:0] mm_addr,
  input  logic [63:0]      mm_wdata,
  output logic             mm_rvalid,
  output logic [63:0]      mm_rdata,
  input  logic [INT_N-1:0] int_level,
  output logic             err_pulse,
  output logic             mmio_en_chg
);
  localparam int NPORT = 2;

  acc_t          sc_acc, mm_acc, sel;
  logic [DW-1:0] rd_val;
  logic          bad, chg;
  logic [NPORT-1:0]     hit, rv;
  logic [DW-1:0]        rd [NPORT];

  assign scn_ready = 1'b1;
  assign mm_ready  = ~scn_valid;

  hb_port_decode #(.ADDR_W(SC_AW), .BASE_IDX(0), .IS_MM(1'b0)) u_sc_dec (
    .valid(scn_valid), .we(scn_we), .addr(scn_addr), .wdata(scn_wdata), .acc(sc_acc));

  hb_port_decode #(.ADDR_W(MM_AW), .BASE_IDX(MM_BASE_IDX), .IS_MM(1'b1)) u_mm_dec (
    .valid(mm_valid), .we(mm_we), .addr(mm_addr), .wdata(mm_wdata), .acc(mm_acc));

  always_comb begin
    if (sc_acc.vld)      sel = sc_acc;
    else if (mm_acc.vld) sel = mm_acc;
    else                 sel = '0;
  end

  hb_reg_core #(
    .INT_N(INT_N), .INT_LSB(INT_LSB), .BAR_DFLT(BAR_DFLT),
    .BAR_MASK(BAR_MASK), .FSP_MASK(FSP_MASK)
  ) u_core (
    .clk(clk), .rst(rst), .acc(sel), .int_level(int_level),
    .rd_val(rd_val), .bad(bad), .mmio_chg(chg));

  assign hit[0] = scn_valid & ~scn_we;
  assign hit[1] = mm_valid & mm_ready & ~mm_we;

  for (genvar p = 0; p < NPORT; p++) begin : g_ret
    hb_read_return #(.W(DW)) u_ret (
      .clk(clk), .rst(rst), .hit(hit[p]), .data(rd_val),
      .rvalid(rv[p]), .rdata(rd[p]));
  end

  assign scn_rvalid = rv[0];
  assign scn_rdata  = rd[0];
  assign mm_rvalid  = rv[1];
  assign mm_rdata   = rd[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse   <= 1'b0;
      mmio_en_chg <= 1'b0;
    end else begin
      err_pulse   <= bad;
      mmio_en_chg <= chg;
    end
  end
endmodule

// File: rtl/hostbridge_regfile_chk.sv
module hostbridge_regfile_chk #(
  parameter int SC_AW = 9,
  parameter int MM_AW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             scn_valid,
  input logic             scn_we,
  input logic [SC_AW-1:0] scn_addr,
  input logic             scn_rvalid,
  input logic             mm_valid,
  input logic             mm_ready,
  input logic             mm_we,
  input logic [MM_AW-1:0] mm_addr,
  input logic             mm_rvalid,
  input logic             err_pulse,
  input logic             mmio_en_chg
);
  // R10
  scan_wins_chk: assert property (@(posedge clk) disable iff (rst)
    scn_valid |-> !mm_ready);

  // R10
  scn_rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (scn_valid && !scn_we) |=> scn_rvalid);

  // R10
  mm_rd_src_chk: assert property (@(posedge clk) disable iff (rst)
    mm_rvalid |-> $past(mm_valid && mm_ready && !mm_we));

  // R5
  base_mm_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (mm_valid && mm_ready && mm_we && mm_addr == '0) |=> err_pulse);

  // R9
  misalign_chk: assert property (@(posedge clk) disable iff (rst)
    (scn_valid && scn_addr[2:0] != 3'b000) |=> err_pulse);

  // R11
  chg_src_chk: assert property (@(posedge clk) disable iff (rst)
    mmio_en_chg |-> $past((scn_valid && scn_we) || (mm_valid && mm_ready && mm_we)));

  // R12
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(scn_valid || (mm_valid && mm_ready)));
endmodule

bind hostbridge_regfile hostbridge_regfile_chk #(.SC_AW(SC_AW), .MM_AW(MM_AW)) u_chk (
  .clk(clk), .rst(rst), .scn_valid(scn_valid), .scn_we(scn_we), .scn_addr(scn_addr),
  .scn_rvalid(scn_rvalid), .mm_valid(mm_valid), .mm_ready(mm_ready), .mm_we(mm_we),
  .mm_addr(mm_addr), .mm_rvalid(mm_rvalid), .err_pulse(err_pulse),
  .mmio_en_chg(mmio_en_chg));

// File: tb/test_hostbridge_regfile.sv
module test_hostbridge_regfile;
  localparam logic [63:0] BAR_DFLT = 64'hFFFF_0123_4567_89AB;
  localparam logic [63:0] BAR_MASK = 64'h0003_FFFF_FFF0_0000;
  localparam logic [63:0] FSP_MASK = 64'h0003_FFFF_0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scn_valid = 1'b0, scn_we = 1'b0, mm_valid = 1'b0, mm_we = 1'b0;
  logic [8:0]  scn_addr = '0;
  logic [7:0]  mm_addr = '0;
  logic [63:0] scn_wdata = '0, mm_wdata = '0;
  logic [4:0]  int_level = '0;
  logic scn_ready, mm_ready, scn_rvalid, mm_rvalid, err_pulse, mmio_en_chg;
  logic [63:0] scn_rdata, mm_rdata;

  int errs = 0;
  int checks = 0;
  logic [63:0] m [64];

  always #2 clk = ~clk;

  hostbridge_regfile #(.BAR_DFLT(BAR_DFLT), .BAR_MASK(BAR_MASK), .FSP_MASK(FSP_MASK))
  i_hostbridge_regfile (
    .clk(clk), .rst(rst),
    .scn_valid(scn_valid), .scn_ready(scn_ready), .scn_we(scn_we), .scn_addr(scn_addr),
    .scn_wdata(scn_wdata), .scn_rvalid(scn_rvalid), .scn_rdata(scn_rdata),
    .mm_valid(mm_valid), .mm_ready(mm_ready), .mm_we(mm_we), .mm_addr(mm_addr),
    .mm_wdata(mm_wdata), .mm_rvalid(mm_rvalid), .mm_rdata(mm_rdata),
    .int_level(int_level), .err_pulse(err_pulse), .mmio_en_chg(mmio_en_chg));

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit readable(input int ix);
    return ix == 'h00 || ix == 'h03 || ix == 'h06 || ix == 'h07 || ix == 'h0A ||
           ix == 'h0B || ix == 'h0E || ix == 'h0F || ix == 'h14 || ix == 'h15;
  endfunction

  // model of R3, R4, R5, R6, R7, R8
  task automatic model_write(input int ix, input logic [63:0] d, input bit mm,
                             output bit e);
    e = 1'b0;
    case (ix)
      'h00: m[0] = d;
      'h01: m[0] = m[0] & d;
      'h02: m[0] = m[0] | d;
      'h03: m[3] = d;
      'h04: m[3] = m[3] & d;
      'h05: m[3] = m[3] | d;
      'h06, 'h07, 'h0E, 'h0F, 'h14: m[ix] = d;
      'h0A: if (mm) e = 1'b1; else m[10] = d & (BAR_MASK | 64'h1);
      'h0B: m[11] = d & FSP_MASK;
      'h12: m[14] = m[14] | d;
      'h13: m[14] = m[14] & ~d;
      default: e = 1'b1;
    endcase
  endtask

  task automatic access(input bit mm, input bit we, input logic [8:0] addr,
                        input logic [63:0] d, input string tag);
    int wide;
    bit ok, e_err, e_chg;
    logic [63:0] e_rd, old_ctl;
    wide = mm ? (int'(addr[7:0]) >> 3) + 10 : int'(addr) >> 3;
    ok = (addr[2:0] == 3'b000) && wide < 64;
    old_ctl = m[14];
    e_err = 1'b0;
    e_rd = '1;
    if (!ok) e_err = 1'b1;
    else if (we) model_write(wide, d, mm, e_err);
    else begin
      e_err = !readable(wide);
      if (!e_err) e_rd = m[wide];
    end
    e_chg = m[14][62] ^ old_ctl[62];
    @(negedge clk);
    if (mm) begin
      mm_valid = 1'b1; mm_we = we; mm_addr = addr[7:0]; mm_wdata = d;
    end else begin
      scn_valid = 1'b1; scn_we = we; scn_addr = addr; scn_wdata = d;
    end
    @(posedge clk);
    #1;
    scn_valid = 1'b0;
    mm_valid = 1'b0;
    if (!we) begin
      if (mm) check(mm_rvalid && mm_rdata == e_rd, tag, mm_rdata, e_rd);
      else    check(scn_rvalid && scn_rdata == e_rd, tag, scn_rdata, e_rd);
    end
    check(err_pulse == e_err && mmio_en_chg == e_chg, {tag, " R12 err/strobe"},
          {62'b0, err_pulse, mmio_en_chg}, {62'b0, e_err, e_chg});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m[i] = '0;
    m[10] = (BAR_DFLT & BAR_MASK) | 64'h1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 outputs idle after reset
    check(!scn_rvalid && !mm_rvalid && !err_pulse && !mmio_en_chg && scn_ready && mm_ready,
          "R1 idle outputs", {58'b0, scn_rvalid, mm_rvalid, err_pulse, mmio_en_chg,
          scn_ready, mm_ready}, 64'h3);

    // R1, R8 reset read sweep
    for (int i = 0; i < 64; i++) access(1'b0, 1'b0, 9'(i << 3), '0, "R1 reset read");

    // R3 R4 R5 R6 R7 R8 write sweep then read back
    for (int i = 0; i < 64; i++)
      access(1'b0, 1'b1, 9'(i << 3),
             64'hC3A5_96F0_0FF0_5A3C ^ (64'(i) * 64'h0102_0408_1020_4080), "R8 write sweep");
    for (int i = 0; i < 64; i++) access(1'b0, 1'b0, 9'(i << 3), '0, "R6 readback");

    // R2 memory-mapped sweep
    for (int o = 0; o < 256; o += 8) access(1'b1, 1'b0, 9'(o), '0, "R2 mm read");

    // R5 base write from memory-mapped port dropped
    access(1'b1, 1'b1, 9'h000, 64'h0001_1111_2222_3333, "R5 mm base write");
    access(1'b0, 1'b0, 9'h050, '0, "R5 base unchanged");
    access(1'b0, 1'b1, 9'h050, 64'hFFFF_FFFF_FFFF_FFFE, "R6 base mask");
    access(1'b0, 1'b0, 9'h050, '0, "R6 base read");

    // R9 misaligned accesses
    access(1'b0, 1'b1, 9'h003, 64'h1234, "R9 misaligned write");
    access(1'b0, 1'b0, 9'h000, '0, "R9 fault unchanged");
    access(1'b1, 1'b0, 9'h005, '0, "R9 misaligned read");

    // R3 aliases via memory-mapped port never reach them; use scan
    access(1'b0, 1'b1, 9'h000, 64'hF0F0_F0F0_F0F0_F0F0, "R3 load");
    access(1'b0, 1'b1, 9'h008, 64'hFF00_FF00_FF00_FF00, "R3 and");
    access(1'b0, 1'b1, 9'h010, 64'h000F_000F_000F_000F, "R3 or");
    access(1'b0, 1'b0, 9'h000, '0, "R3 result");

    // R11 R4 enable bit toggles
    access(1'b0, 1'b1, 9'h070, 64'h0, "R4 ctl clear");
    access(1'b0, 1'b1, 9'h090, 64'h4000_0000_0000_0001, "R11 set rises");
    access(1'b0, 1'b1, 9'h090, 64'h4000_0000_0000_0000, "R11 set again");
    access(1'b1, 1'b1, 9'h048, 64'h0000_0000_0000_0001, "R11 mm clear alias");
    access(1'b0, 1'b0, 9'h070, '0, "R4 ctl read");
    access(1'b1, 1'b1, 9'h020, 64'h4000_0000_0000_0000, "R11 mm direct ctl");

    // R7 status follows levels, write ignored
    @(negedge clk);
    int_level = 5'b10110;
    m['h15] = 64'(5'b10110) << 32;
    repeat (2) @(posedge clk);
    access(1'b1, 1'b0, 9'h058, '0, "R7 status read");
    access(1'b1, 1'b1, 9'h058, 64'hFFFF, "R7 status write");
    access(1'b0, 1'b0, 9'h0A8, '0, "R7 status kept");

    // R10 collision and latency
    @(negedge clk);
    scn_valid = 1'b1; scn_we = 1'b0; scn_addr = 9'h000;
    mm_valid = 1'b1; mm_we = 1'b0; mm_addr = 8'h00;
    #1;
    check(!mm_ready, "R10 mm stalled", {63'b0, mm_ready}, 64'h0);
    @(posedge clk);
    #1;
    scn_valid = 1'b0;
    mm_valid = 1'b0;
    check(scn_rvalid && !mm_rvalid && scn_rdata == m[0], "R10 scan wins",
          scn_rdata, m[0]);
    @(posedge clk);
    #1;
    check(!scn_rvalid && !err_pulse, "R10 one cycle valid",
          {62'b0, scn_rvalid, err_pulse}, 64'h0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule